// File: doc/BRIEF.md
# Transmit Dominant Timeout and Fault Gate

This block sits in one transceiver channel, between the transmit-data pin and the bus driver. It turns a low level on the transmit input into a dominant-drive command. It withdraws that command when the input stays low too long, when the die is too hot, or when the supply is too low. The transmit pin is asynchronous, so it passes through a synchronizer that resets to the high (recessive) level. A falling edge of the synchronized input starts a dominant-run timer. A rising edge clears that timer and any timeout block.

Each of the three faults sets its own sticky status bit, and the driver stays recessive while any bit is set. The status bit clears together with the block it reports. A thermal or undervoltage block can only end while the transmit input is high. An undervoltage block also needs an extra settling delay. Because of this rule, a transmit line that is still low after a fault clears cannot resume dominant drive in the middle of a bit.

The timeout must be longer than the longest legal dominant run at the slowest bit rate the network uses. Both the timeout and the undervoltage settling delay are parameters counted in clock cycles.

Top module: `txd_guard`

## Requirements
- R1: While reset is asserted and right after it is released, drvDominant is 0 and all three status bits are 0.
- R2: With normalEn high and no fault, drvDominant goes to 1 two clock edges after txdIn goes low (synchronizer latency). It returns to 0 two edges after txdIn goes high.
- R3: If the synchronized input stays low for DOM_TIMEOUT_CYC clock edges after its falling edge, drvDominant drops to 0 and statTimeout is set, while the input is still low.
- R4: A return of the synchronized input to high clears statTimeout on the next edge. The next falling edge again grants a full DOM_TIMEOUT_CYC window.
- R5: overTemp high forces drvDominant to 0 in the same cycle and sets statThermal on the next edge.
- R6: After overTemp falls, statThermal and the driver block stay in place as long as the synchronized input is low. They clear on the first edge at which the input is seen high.
- R7: underVolt high forces drvDominant to 0 in the same cycle and sets statUndervolt on the next edge.
- R8: After underVolt falls, statUndervolt clears only after REC_DELAY_CYC consecutive edges with the synchronized input high. A low input during that delay restarts it.
- R9: normalEn low holds drvDominant at 0 and leaves the status bits untouched. Raising normalEn while the input is low and no fault is present restores dominant drive at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txdIn | input | 1 | Transmit-data pin, low means dominant, asynchronous |
| overTemp | input | 1 | Over-temperature flag, synchronous |
| underVolt | input | 1 | Supply undervoltage flag, synchronous |
| normalEn | input | 1 | Normal-mode enable for the driver |
| drvDominant | output | 1 | Command to drive the bus dominant |
| statTimeout | output | 1 | Dominant timeout block active |
| statThermal | output | 1 | Thermal block active |
| statUndervolt | output | 1 | Undervoltage block active |

## Verification
On every cycle the assertions check several rules. The timeout latch can only set while the input is low and always clears once the input is high. A thermal block never lifts while the input is low. An undervoltage block only lifts on a cycle with the supply good and the input high. The counters never exceed their limits. The exact cycle counts can only be shown by the directed scenarios, which observe the ports. These cover the two-edge pass-through delay, the length of the timeout window and its fresh restart, the undervoltage settling delay and its restart, and the same-cycle cut-off on a raw fault flag.

// File: rtl/txg_pkg.sv
package txg_pkg;

  // Run strobes issued by the control to the counters.
  typedef struct packed {
    logic domRun;  // advance the dominant-run timer
    logic recRun;  // advance the undervoltage settling counter
  } txgStrobe_t;

  // Observations returned by the datapath to the control.
  typedef struct packed {
    logic txdHigh;     // synchronized transmit level
    logic domExpired;  // timer sits at its last allowed count
    logic recDone;     // settling counter sits at its last count
  } txgObs_t;

endpackage

// File: rtl/txg_datapath.sv
module txg_datapath
  import txg_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int DOM_TIMEOUT_CYC = 64,
  parameter int REC_DELAY_CYC   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txdIn,
  input  txgStrobe_t strobe,
  output txgObs_t    obs
);

  localparam int DOM_W = $clog2(DOM_TIMEOUT_CYC + 1);
  localparam int REC_W = $clog2(REC_DELAY_CYC + 1);
  localparam logic [DOM_W-1:0] DOM_LAST = DOM_W'(DOM_TIMEOUT_CYC - 1);
  localparam logic [REC_W-1:0] REC_LAST = REC_W'(REC_DELAY_CYC - 1);

  logic txdSync;

  generate
    if (SYNC_STAGES < 2) begin : g_sync1
      logic syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= 1'b1;
        else       syncQ <= txdIn;
      end
      assign txdSync = syncQ;
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], txdIn};
      end
      assign txdSync = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  logic [DOM_W-1:0] domCnt;
  logic [REC_W-1:0] recCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      domCnt <= '0;
      recCnt <= '0;
    end else begin
      if (!strobe.domRun)        domCnt <= '0;
      else if (domCnt != DOM_LAST) domCnt <= domCnt + 1'b1;
      if (!strobe.recRun)        recCnt <= '0;
      else if (recCnt != REC_LAST) recCnt <= recCnt + 1'b1;
    end
  end

  assign obs.txdHigh    = txdSync;
  assign obs.domExpired = (domCnt == DOM_LAST);
  assign obs.recDone    = (recCnt == REC_LAST);

  AST_DOM_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    domCnt <= DOM_LAST); // R3
  AST_REC_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    recCnt <= REC_LAST); // R8

endmodule

// File: rtl/txg_control.sv
module txg_control
  import txg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       overTemp,
  input  logic       underVolt,
  input  txgObs_t    obs,
  output txgStrobe_t strobe,
  output logic       toLatch,
  output logic       thLatch,
  output logic       uvLatch
);

  always_comb begin
    strobe.domRun = !obs.txdHigh && !toLatch;
    strobe.recRun = uvLatch && !underVolt && obs.txdHigh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toLatch <= 1'b0;
      thLatch <= 1'b0;
      uvLatch <= 1'b0;
    end else begin
      if (obs.txdHigh)                          toLatch <= 1'b0;
      else if (strobe.domRun && obs.domExpired) toLatch <= 1'b1;

      if (overTemp)         thLatch <= 1'b1;
      else if (obs.txdHigh) thLatch <= 1'b0;

      if (underVolt)                          uvLatch <= 1'b1;
      else if (strobe.recRun && obs.recDone)  uvLatch <= 1'b0;
    end
  end

  AST_TO_SET_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toLatch) |-> !$past(obs.txdHigh)); // R3
  AST_TO_CLEAR_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (toLatch && obs.txdHigh) |=> !toLatch); // R4
  AST_TH_HOLD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (thLatch && !obs.txdHigh) |=> thLatch); // R6
  AST_UV_CLEAR_OK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(uvLatch) |-> ($past(obs.txdHigh) && !$past(underVolt))); // R8

endmodule

// File: rtl/txd_guard.sv
module txd_guard
  import txg_pkg::*;
#(
  parameter int SYNC_STAGES     = 2,
  parameter int DOM_TIMEOUT_CYC = 64,
  parameter int REC_DELAY_CYC   = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic txdIn,
  input  logic overTemp,
  input  logic underVolt,
  input  logic normalEn,
  output logic drvDominant,
  output logic statTimeout,
  output logic statThermal,
  output logic statUndervolt
);

  txgStrobe_t strobe;
  txgObs_t    obs;
  logic       toLatch, thLatch, uvLatch;

  txg_datapath #(
    .SYNC_STAGES    (SYNC_STAGES),
    .DOM_TIMEOUT_CYC(DOM_TIMEOUT_CYC),
    .REC_DELAY_CYC  (REC_DELAY_CYC)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .txdIn (txdIn),
    .strobe(strobe),
    .obs   (obs)
  );

  txg_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .overTemp (overTemp),
    .underVolt(underVolt),
    .obs      (obs),
    .strobe   (strobe),
    .toLatch  (toLatch),
    .thLatch  (thLatch),
    .uvLatch  (uvLatch)
  );

  assign drvDominant = normalEn && !obs.txdHigh && !toLatch && !thLatch &&
                       !uvLatch && !overTemp && !underVolt;
  assign statTimeout   = toLatch;
  assign statThermal   = thLatch;
  assign statUndervolt = uvLatch;

endmodule

// File: tb/sim_txd_guard.sv
module sim_txd_guard;

  localparam int DOM_T = 20;
  localparam int REC_T = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txdIn = 1'b1;
  logic overTemp = 1'b0;
  logic underVolt = 1'b0;
  logic normalEn = 1'b1;
  logic drvDominant, statTimeout, statThermal, statUndervolt;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  txd_guard #(.SYNC_STAGES(2), .DOM_TIMEOUT_CYC(DOM_T), .REC_DELAY_CYC(REC_T)) u0 (
    .clk(clk), .rstN(rstN), .txdIn(txdIn), .overTemp(overTemp),
    .underVolt(underVolt), .normalEn(normalEn), .drvDominant(drvDominant),
    .statTimeout(statTimeout), .statThermal(statThermal),
    .statUndervolt(statUndervolt)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic test_reset();
    step(2);
    chk("R1 drv in reset", drvDominant, 1'b0);
    chk("R1 timeout in reset", statTimeout, 1'b0);
    rstN = 1'b1;
    step(2);
    chk("R1 drv after reset", drvDominant, 1'b0);
    chk("R1 thermal after reset", statThermal, 1'b0);
    chk("R1 undervolt after reset", statUndervolt, 1'b0);
  endtask

  task automatic test_pass();
    txdIn = 1'b0;
    step(1);
    chk("R2 one edge still recessive", drvDominant, 1'b0);
    step(1);
    chk("R2 dominant after two edges", drvDominant, 1'b1);
    txdIn = 1'b1;
    step(1);
    chk("R2 release one edge", drvDominant, 1'b1);
    step(1);
    chk("R2 recessive after two edges", drvDominant, 1'b0);
    step(3);
  endtask

  task automatic test_timeout();
    txdIn = 1'b0;
    step(DOM_T + 1);
    chk("R3 last dominant cycle", drvDominant, 1'b1);
    chk("R3 no timeout yet", statTimeout, 1'b0);
    step(1);
    chk("R3 driver cut", drvDominant, 1'b0);
    chk("R3 timeout flag", statTimeout, 1'b1);
    step(5);
    chk("R3 stays cut while low", drvDominant, 1'b0);
    txdIn = 1'b1;
    step(2);
    chk("R4 flag before clear edge", statTimeout, 1'b1);
    step(1);
    chk("R4 flag cleared", statTimeout, 1'b0);
    txdIn = 1'b0;
    step(DOM_T + 1);
    chk("R4 fresh full window", drvDominant, 1'b1);
    step(1);
    chk("R4 second timeout", statTimeout, 1'b1);
    txdIn = 1'b1;
    step(4);
  endtask

  task automatic test_thermal();
    txdIn = 1'b0;
    step(3);
    chk("R5 dominant before fault", drvDominant, 1'b1);
    overTemp = 1'b1;
    #1;
    chk("R5 same-cycle cut", drvDominant, 1'b0);
    step(1);
    chk("R5 thermal flag", statThermal, 1'b1);
    overTemp = 1'b0;
    step(3);
    chk("R6 held while low", statThermal, 1'b1);
    chk("R6 driver still blocked", drvDominant, 1'b0);
    txdIn = 1'b1;
    step(3);
    chk("R6 cleared after high", statThermal, 1'b0);
    txdIn = 1'b0;
    step(2);
    chk("R6 dominant resumes", drvDominant, 1'b1);
    txdIn = 1'b1;
    step(4);
  endtask

  task automatic test_undervolt();
    txdIn = 1'b0;
    step(2);
    chk("R7 dominant before fault", drvDominant, 1'b1);
    underVolt = 1'b1;
    #1;
    chk("R7 same-cycle cut", drvDominant, 1'b0);
    step(1);
    chk("R7 undervolt flag", statUndervolt, 1'b1);
    underVolt = 1'b0;
    step(5);
    chk("R8 held while low", statUndervolt, 1'b1);
    chk("R8 driver blocked while low", drvDominant, 1'b0);
    txdIn = 1'b1;
    step(REC_T + 1);
    chk("R8 still settling", statUndervolt, 1'b1);
    step(1);
    chk("R8 cleared after delay", statUndervolt, 1'b0);
    // restart: drop input part way through the settling delay
    underVolt = 1'b1;
    step(1);
    underVolt = 1'b0;
    step(4);
    txdIn = 1'b0;
    step(6);
    chk("R8 restart blocks driver", drvDominant, 1'b0);
    txdIn = 1'b1;
    step(REC_T + 1);
    chk("R8 restarted delay not done", statUndervolt, 1'b1);
    step(1);
    chk("R8 restarted delay done", statUndervolt, 1'b0);
    step(2);
  endtask

  task automatic test_enable();
    normalEn = 1'b0;
    txdIn = 1'b0;
    step(3);
    chk("R9 disabled recessive", drvDominant, 1'b0);
    chk("R9 no timeout status", statTimeout, 1'b0);
    chk("R9 no thermal status", statThermal, 1'b0);
    normalEn = 1'b1;
    #1;
    chk("R9 enable restores dominant", drvDominant, 1'b1);
    txdIn = 1'b1;
    step(4);
  endtask

  initial begin
    test_reset();
    test_pass();
    test_timeout();
    test_thermal();
    test_undervolt();
    test_enable();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule